// File: doc/BRIEF.md
# I2C Slave Bus Status Tracker

This unit runs next to an I2C slave byte engine and keeps the per-transfer status that a host reads back. It watches the already-synchronized SDA and SCL lines for START and STOP conditions. It also takes single-cycle event strobes from the byte engine: an address byte matched, a data byte finished, a NACK was seen, the host read the buffer, the host loaded a byte for transmit, or the host rewrote the compare address.

From these inputs it keeps six flags: the most recent bus condition (START or STOP), whether the last byte was an address or data, the transfer direction latched at the address match, a buffer-full flag, and a request to reload the compare address in 10-bit mode. The flags are presented as one 8-bit status word. The word is registered, so each event shows on the word one clock after the cycle that carries it.

The direction flag is valid only from an address match until the next START, STOP or NACK. It reads 0 outside that window, so the word never reports an old direction.

Top module: `i2c_slv_status`

## Requirements
- R1: A START (SDA high in one cycle and low in the next, with SCL high in both) while en_i is high sets status bit 3 and clears bit 4 on the next clock.
- R2: A STOP (SDA low in one cycle and high in the next, with SCL high in both) while en_i is high sets status bit 4 and clears bit 3 on the next clock.
- R3: While en_i is low, status bits 3 and 4 are 0 from the next clock onward, and START or STOP conditions are ignored. The other flags keep their values.
- R4: addr_match_i clears status bit 5 and loads rw_bit_i (1 = read, 0 = write) into status bit 2. byte_done_i without addr_match_i sets bit 5.
- R5: Status bit 2 is cleared by a START, a STOP or nack_i, unless addr_match_i is high in the same cycle, in which case R4 applies.
- R6: The buffer-full flag, status bit 0, is set by any of these: addr_match_i, byte_done_i while bit 2 is 0 (receive), or tx_load_i. It is cleared by buf_read_i, or by byte_done_i while bit 2 is 1 (transmit shift finished). A set wins over a clear in the same cycle.
- R7: The update-address flag, status bit 1, is set by addr_match_i while ten_bit_i is high and cleared by addr_wr_i. A set wins over a clear.
- R8: Status bits 7 and 6 always read 0.
- R9: While rst_ni is low, the whole status word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Module enable |
| sda_i | input | 1 | Synchronized SDA level |
| scl_i | input | 1 | Synchronized SCL level |
| byte_done_i | input | 1 | Data byte finished (strobe) |
| addr_match_i | input | 1 | Address byte matched (strobe) |
| rw_bit_i | input | 1 | R/W bit of the matched address |
| nack_i | input | 1 | NACK seen (strobe) |
| buf_read_i | input | 1 | Host read the buffer (strobe) |
| tx_load_i | input | 1 | Host loaded a transmit byte (strobe) |
| ten_bit_i | input | 1 | 10-bit addressing mode |
| addr_wr_i | input | 1 | Host rewrote the compare address (strobe) |
| status_o | output | 8 | Packed status word |

## Verification
The assertions check on every cycle the following:
- START and STOP update the condition flags as R1 and R2 require, and the two flags are never set together.
- Disabling clears both condition flags.
- An address match loads the direction bit and clears the data flag.
- A NACK clears the direction bit.
- The two top bits stay 0.

Only the bench scenarios can show the flag state across whole transactions: a write transaction, a read transaction with a transmit load, a repeated START, a 10-bit update-address request, and the set-over-clear priorities. The same holds for conditions that are ignored while the module is disabled.

// File: rtl/i2c_slv_status_pkg.sv
package i2c_slv_status_pkg;
  localparam int unsigned STAT_W = 8;
  localparam int unsigned RSVD_W = STAT_W - 6;

  typedef struct packed {
    logic [RSVD_W-1:0] rsvd;
    logic              data_last;
    logic              stop_seen;
    logic              start_seen;
    logic              rd_dir;
    logic              addr_upd;
    logic              buf_full;
  } stat_t;

  typedef struct packed {
    logic start;
    logic stop;
  } cond_t;
endpackage

// File: rtl/i2c_bus_cond_det.sv
module i2c_bus_cond_det
  import i2c_slv_status_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  sda_i,
  input  logic  scl_i,
  output cond_t cond_o,
  output logic  start_seen_o,
  output logic  stop_seen_o
);
  logic sda_q, scl_q;
  logic scl_hi;
  logic start_q, stop_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_i;
      scl_q <= scl_i;
    end
  end

  assign scl_hi       = scl_q & scl_i;
  assign cond_o.start = en_i & scl_hi & sda_q & ~sda_i;
  assign cond_o.stop  = en_i & scl_hi & ~sda_q & sda_i;

  // most recent condition wins; disable wipes both
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else if (!en_i) begin
      start_q <= 1'b0;
      stop_q  <= 1'b0;
    end else if (cond_o.start) begin
      start_q <= 1'b1;
      stop_q  <= 1'b0;
    end else if (cond_o.stop) begin
      start_q <= 1'b0;
      stop_q  <= 1'b1;
    end
  end

  assign start_seen_o = start_q;
  assign stop_seen_o  = stop_q;
endmodule

// File: rtl/i2c_xfer_flags.sv
module i2c_xfer_flags
  import i2c_slv_status_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  cond_t cond_i,
  input  logic  byte_done_i,
  input  logic  addr_match_i,
  input  logic  rw_bit_i,
  input  logic  nack_i,
  input  logic  buf_read_i,
  input  logic  tx_load_i,
  input  logic  ten_bit_i,
  input  logic  addr_wr_i,
  output logic  data_last_o,
  output logic  rd_dir_o,
  output logic  buf_full_o,
  output logic  addr_upd_o
);
  logic da_q, rw_q, bf_q, ua_q;
  logic bf_set, bf_clr, rw_kill, ua_set;

  assign rw_kill = cond_i.start | cond_i.stop | nack_i;
  assign bf_set  = addr_match_i | (byte_done_i & ~rw_q) | tx_load_i;
  assign bf_clr  = buf_read_i | (byte_done_i & rw_q);
  assign ua_set  = addr_match_i & ten_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      da_q <= 1'b0;
      rw_q <= 1'b0;
      bf_q <= 1'b0;
      ua_q <= 1'b0;
    end else begin
      if (addr_match_i)     da_q <= 1'b0;
      else if (byte_done_i) da_q <= 1'b1;

      if (addr_match_i)     rw_q <= rw_bit_i;
      else if (rw_kill)     rw_q <= 1'b0;

      if (bf_set)           bf_q <= 1'b1;
      else if (bf_clr)      bf_q <= 1'b0;

      if (ua_set)           ua_q <= 1'b1;
      else if (addr_wr_i)   ua_q <= 1'b0;
    end
  end

  assign data_last_o = da_q;
  assign rd_dir_o    = rw_q;
  assign buf_full_o  = bf_q;
  assign addr_upd_o  = ua_q;
endmodule

// File: rtl/i2c_status_pack.sv
module i2c_status_pack
  import i2c_slv_status_pkg::*;
(
  input  logic              data_last_i,
  input  logic              stop_seen_i,
  input  logic              start_seen_i,
  input  logic              rd_dir_i,
  input  logic              addr_upd_i,
  input  logic              buf_full_i,
  output logic [STAT_W-1:0] word_o
);
  stat_t s;
  always_comb begin
    s            = '0;
    s.data_last  = data_last_i;
    s.stop_seen  = stop_seen_i;
    s.start_seen = start_seen_i;
    s.rd_dir     = rd_dir_i;
    s.addr_upd   = addr_upd_i;
    s.buf_full   = buf_full_i;
  end
  assign word_o = s;
endmodule

// File: rtl/i2c_slv_status.sv
module i2c_slv_status
  import i2c_slv_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              sda_i,
  input  logic              scl_i,
  input  logic              byte_done_i,
  input  logic              addr_match_i,
  input  logic              rw_bit_i,
  input  logic              nack_i,
  input  logic              buf_read_i,
  input  logic              tx_load_i,
  input  logic              ten_bit_i,
  input  logic              addr_wr_i,
  output logic [STAT_W-1:0] status_o
);
  cond_t cond;
  logic  start_seen, stop_seen, data_last, rd_dir, buf_full, addr_upd;

  i2c_bus_cond_det u_cond (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .sda_i        (sda_i),
    .scl_i        (scl_i),
    .cond_o       (cond),
    .start_seen_o (start_seen),
    .stop_seen_o  (stop_seen)
  );

  i2c_xfer_flags u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cond_i       (cond),
    .byte_done_i  (byte_done_i),
    .addr_match_i (addr_match_i),
    .rw_bit_i     (rw_bit_i),
    .nack_i       (nack_i),
    .buf_read_i   (buf_read_i),
    .tx_load_i    (tx_load_i),
    .ten_bit_i    (ten_bit_i),
    .addr_wr_i    (addr_wr_i),
    .data_last_o  (data_last),
    .rd_dir_o     (rd_dir),
    .buf_full_o   (buf_full),
    .addr_upd_o   (addr_upd)
  );

  i2c_status_pack u_pack (
    .data_last_i  (data_last),
    .stop_seen_i  (stop_seen),
    .start_seen_i (start_seen),
    .rd_dir_i     (rd_dir),
    .addr_upd_i   (addr_upd),
    .buf_full_i   (buf_full),
    .word_o       (status_o)
  );
endmodule

// File: rtl/i2c_slv_status_chk.sv
module i2c_slv_status_chk
  import i2c_slv_status_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              sda_i,
  input logic              scl_i,
  input logic              addr_match_i,
  input logic              rw_bit_i,
  input logic              nack_i,
  input logic [STAT_W-1:0] status_o
);
  a_r1_start_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && scl_i && $past(scl_i) && $past(sda_i) && !sda_i)
      |=> (status_o[3] && !status_o[4]));

  a_r2_stop_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && scl_i && $past(scl_i) && !$past(sda_i) && sda_i)
      |=> (status_o[4] && !status_o[3]));

  a_r3_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (status_o[4:3] == 2'b00));

  a_r1_not_both: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(status_o[3] && status_o[4]));

  a_r4_addr_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_match_i |=> (!status_o[5] && status_o[2] == $past(rw_bit_i)));

  a_r5_nack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nack_i && !addr_match_i) |=> !status_o[2]);

  a_r8_rsvd_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:6] == 2'b00);
endmodule

bind i2c_slv_status i2c_slv_status_chk u_chk (.*);

// File: tb/tb_i2c_slv_status.sv
module tb_i2c_slv_status;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic en_i, sda_i, scl_i, byte_done_i, addr_match_i, rw_bit_i, nack_i;
  logic buf_read_i, tx_load_i, ten_bit_i, addr_wr_i;
  logic [7:0] status_o;
  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  i2c_slv_status dut (.*);

  // ctrl order: en sda scl byte_done addr_match rw nack buf_read tx_load ten_bit addr_wr
  localparam int NV = 26;
  localparam logic [18:0] VEC [NV] = '{
    {11'b11100000000, 8'h00}, // idle
    {11'b10100000000, 8'h08}, // START (R1)
    {11'b10000000000, 8'h08},
    {11'b10001000000, 8'h09}, // addr write (R4 R6)
    {11'b10000001000, 8'h08}, // host read
    {11'b10010000000, 8'h29}, // rx data byte
    {11'b10000001000, 8'h28},
    {11'b10100000000, 8'h28},
    {11'b11100000000, 8'h30}, // STOP (R2)
    {11'b10100000000, 8'h28}, // START
    {11'b10000000000, 8'h28},
    {11'b10001100000, 8'h0d}, // addr read
    {11'b10000001000, 8'h0c},
    {11'b10000000100, 8'h0d}, // tx load
    {11'b10010000000, 8'h2c}, // tx shift done
    {11'b11000000000, 8'h2c},
    {11'b11100000000, 8'h2c},
    {11'b10100000000, 8'h28}, // repeated START clears dir (R5)
    {11'b10000000000, 8'h28},
    {11'b10001100000, 8'h0d},
    {11'b10000010000, 8'h09}, // NACK (R5)
    {11'b10001000010, 8'h0b}, // 10-bit match (R7)
    {11'b10000000001, 8'h09},
    {11'b10000001000, 8'h08},
    {11'b00000000000, 8'h00}, // disable (R3)
    {11'b11000000000, 8'h00}
  };

  task automatic drive(input logic [10:0] c);
    {en_i, sda_i, scl_i, byte_done_i, addr_match_i, rw_bit_i, nack_i,
     buf_read_i, tx_load_i, ten_bit_i, addr_wr_i} = c;
  endtask

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, got, exp);
    end
  endtask

  task automatic step(input logic [10:0] c, input string req, input logic [7:0] exp);
    drive(c);
    @(negedge clk_i);
    check(req, status_o, exp);
    check("R8", {status_o[7:6], 6'b0}, 8'h00);
  endtask

  initial begin
    drive(11'b01100000000);
    repeat (3) @(negedge clk_i);
    check("R9 reset", status_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    for (int i = 0; i < NV; i++)
      step(VEC[i][18:8], $sformatf("vec%0d R1 R2 R3 R4 R5 R6 R7", i), VEC[i][7:0]);

    // R3: conditions ignored while disabled
    step(11'b01100000000, "R3 idle off", 8'h00);
    step(11'b00100000000, "R3 start ignored", 8'h00);
    step(11'b01100000000, "R3 stop ignored", 8'h00);
    // R3: other flags retained across disable
    step(11'b00001100000, "R3 match while off", 8'h05);
    step(11'b00000000000, "R3 keep", 8'h05);
    // R6: set wins over clear
    step(11'b00000001100, "R6 set wins", 8'h05);
    step(11'b00000001000, "R6 clear", 8'h04);
    // R5: match beats nack
    step(11'b00001110000, "R5 match beats nack", 8'h05);
    // R7: set beats addr_wr
    step(11'b00001000011, "R7 set wins", 8'h03);
    // R9: mid-run reset
    rst_ni = 1'b0;
    #1;
    check("R9 async reset", status_o, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step(11'b11100000000, "R9 after reset", 8'h00);
    step(11'b10100000000, "R1 start again", 8'h08);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog R9: actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule